// File: doc/BRIEF.md
# Double-Precision Compare Condition Unit

This unit takes two 64-bit IEEE-754 double-precision operands and classifies their relation as less-than, greater-than, equal or unordered. The resulting 4-bit condition code is written into one chosen 4-bit field of a 32-bit condition register and into the floating-point condition bits of a 32-bit status register. The caller supplies the current values of both registers with each request and takes back the updated copies.

A 10-bit operation selector picks the quiet compare, which reports NaN operands as unordered, or the signalling compare, which raises an invalid-operation trap on any NaN. A 5-bit target operand names the condition-register field in its upper three bits. Malformed selectors or targets are flagged as illegal forms.

The request interface carries a valid strobe and no ready signal. The unit accepts a request on every cycle and never applies back-pressure. Each accepted request yields one result on the following clock edge, marked by a single-cycle done pulse. The outputs then hold until the next request.

Top module: `fp_cmp_cond`

## Requirements
- R1: When either operand is a NaN (exponent all ones, fraction nonzero), the code is unordered, 4'b0001.
- R2: For non-NaN operands the code has exactly one bit set. It is tested as equal (4'b0010) first, then less-than (4'b1000), otherwise greater-than (4'b0100). Ordering follows the real values and covers infinities and negative numbers.
- R3: Positive zero and negative zero compare as equal.
- R4: A selector of 0 chooses the quiet compare and 32 chooses the signalling compare. Any other selector sets illegal, and both registers are returned unchanged.
- R5: A target operand whose two low bits are not both zero sets illegal, and both registers are returned unchanged. Illegal takes priority over trap.
- R6: In the signalling compare, a NaN operand sets trap and both registers are returned unchanged. The quiet compare never sets trap.
- R7: On completion, status bit 15 is cleared and the code is placed at status bits 14..11 (LT, GT, EQ, UN from high to low). All other status bits keep their input values.
- R8: Only the condition-register field named by target bits 4..2 is replaced by the code. Field 0 is bits 31..28 and field 7 is bits 3..0. All other fields keep their input values.
- R9: Results register on the clock edge after valid is sampled high, and done pulses for exactly that one cycle. Without valid, all outputs hold.
- R10: During reset, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request strobe, accepted every cycle |
| opnd_a | input | 64 | First double operand |
| opnd_b | input | 64 | Second double operand |
| tgt_field | input | 5 | Target field operand; bits 4..2 index the field, bits 1..0 must be zero |
| ext_op | input | 10 | Selector: 0 quiet, 32 signalling |
| cr_in | input | 32 | Current condition register |
| fs_in | input | 32 | Current status register |
| cr_out | output | 32 | Updated condition register |
| fs_out | output | 32 | Updated status register |
| done | output | 1 | One-cycle completion pulse |
| illegal | output | 1 | Illegal form for the completed request |
| trap | output | 1 | Invalid-operation trap for the completed request |

## Verification
Random operand pairs are drawn from raw bit patterns, small signed integers, shared values, zeros of both signs, infinities and quiet and signalling NaNs. This mix separates sign-magnitude ordering mistakes from equality and NaN-detection mistakes. Selectors and targets are mostly legal, with some random values mixed in, so that illegal forms, traps and completions occur together with random register contents. This exposes wrong field positions and leaked status bits. Directed cases then pin down both ends of the field range, the zero-sign rule, the precedence of illegal over trap, and that done falls and outputs hold after one cycle.

// File: rtl/fpc_pkg.sv
package fpc_pkg;
  localparam int DBL_W = 64;
  localparam int EXP_W = 11;
  localparam int FRAC_W = DBL_W - EXP_W - 1;
  localparam int CC_W = 4;

  typedef logic [CC_W-1:0] cc_t;

  localparam cc_t CC_LT = 4'b1000;
  localparam cc_t CC_GT = 4'b0100;
  localparam cc_t CC_EQ = 4'b0010;
  localparam cc_t CC_UN = 4'b0001;

  function automatic logic dbl_is_nan(input logic [DBL_W-1:0] v);
    return (&v[DBL_W-2 -: EXP_W]) && (|v[FRAC_W-1:0]);
  endfunction
endpackage

// File: rtl/fpc_order.sv
module fpc_order
  import fpc_pkg::*;
(
  input  logic [DBL_W-1:0] a,
  input  logic [DBL_W-1:0] b,
  output cc_t              code,
  output logic             any_nan
);
  localparam int MAG_W = DBL_W - 1;

  logic             sa, sb;
  logic [MAG_W-1:0] ma, mb;
  logic             eq, lt;

  always_comb begin
    sa = a[DBL_W-1];
    sb = b[DBL_W-1];
    ma = a[MAG_W-1:0];
    mb = b[MAG_W-1:0];
    any_nan = dbl_is_nan(a) || dbl_is_nan(b);
    eq = ((ma == '0) && (mb == '0)) || (a == b);
    unique case ({sa, sb})
      2'b10:   lt = 1'b1;
      2'b01:   lt = 1'b0;
      2'b00:   lt = ma < mb;
      default: lt = ma > mb;
    endcase
    if (any_nan)  code = CC_UN;
    else if (eq)  code = CC_EQ;
    else if (lt)  code = CC_LT;
    else          code = CC_GT;
  end
endmodule

// File: rtl/fpc_field_merge.sv
module fpc_field_merge #(
  parameter int REG_W = 32,
  parameter int NIB_W = 4,
  localparam int NFIELD = REG_W / NIB_W,
  localparam int SEL_W = $clog2(NFIELD)
) (
  input  logic [REG_W-1:0] base,
  input  logic [SEL_W-1:0] sel,
  input  logic [NIB_W-1:0] nib,
  output logic [REG_W-1:0] merged
);
  for (genvar g = 0; g < NFIELD; g++) begin : g_field
    localparam int HI = REG_W - 1 - g * NIB_W;
    assign merged[HI -: NIB_W] = (sel == SEL_W'(g)) ? nib : base[HI -: NIB_W];
  end
endmodule

// File: rtl/fp_cmp_cond.sv
module fp_cmp_cond
  import fpc_pkg::*;
#(
  parameter int REG_W = 32,
  parameter int XOP_W = 10,
  parameter int QUIET_OP = 0,
  parameter int SIGNAL_OP = 32,
  parameter int FS_CC_LO = 11,
  localparam int NFIELD = REG_W / CC_W,
  localparam int SEL_W = $clog2(NFIELD),
  localparam int TGT_W = SEL_W + 2,
  localparam int FS_CC_HI = FS_CC_LO + CC_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [DBL_W-1:0] opnd_a,
  input  logic [DBL_W-1:0] opnd_b,
  input  logic [TGT_W-1:0] tgt_field,
  input  logic [XOP_W-1:0] ext_op,
  input  logic [REG_W-1:0] cr_in,
  input  logic [REG_W-1:0] fs_in,
  output logic [REG_W-1:0] cr_out,
  output logic [REG_W-1:0] fs_out,
  output logic             done,
  output logic             illegal,
  output logic             trap
);
  cc_t              code;
  logic             any_nan;
  logic [REG_W-1:0] cr_merged;
  logic [REG_W-1:0] fs_merged;
  logic             bad_form, do_trap, complete;

  fpc_order u_order (
    .a(opnd_a), .b(opnd_b), .code(code), .any_nan(any_nan)
  );

  fpc_field_merge #(.REG_W(REG_W), .NIB_W(CC_W)) u_merge (
    .base(cr_in), .sel(tgt_field[TGT_W-1:2]), .nib(code), .merged(cr_merged)
  );

  always_comb begin
    bad_form = ((ext_op != XOP_W'(QUIET_OP)) && (ext_op != XOP_W'(SIGNAL_OP)))
               || (tgt_field[1:0] != 2'b00);
    do_trap  = !bad_form && (ext_op == XOP_W'(SIGNAL_OP)) && any_nan;
    complete = !bad_form && !do_trap;
    fs_merged = fs_in;
    fs_merged[FS_CC_HI:FS_CC_LO] = {1'b0, code};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cr_out  <= '0;
      fs_out  <= '0;
      done    <= 1'b0;
      illegal <= 1'b0;
      trap    <= 1'b0;
    end else begin
      done <= in_valid;
      if (in_valid) begin
        illegal <= bad_form;
        trap    <= do_trap;
        cr_out  <= complete ? cr_merged : cr_in;
        fs_out  <= complete ? fs_merged : fs_in;
      end
    end
  end

  // R9: done follows the strobe by exactly one edge
  a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> done);
  a_r9_done_low: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !done);
  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(cr_out) && $stable(fs_out)));
  // R4 / R5 / R6: faults return registers untouched
  a_r4_fault_keeps_regs: assert property (@(posedge clk) disable iff (!rst_n)
    (done && (illegal || trap)) |-> (cr_out == $past(cr_in) && fs_out == $past(fs_in)));
  a_r5_illegal_over_trap: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !(illegal && trap));
  a_r6_trap_only_signalling: assert property (@(posedge clk) disable iff (!rst_n)
    (done && trap) |-> ($past(ext_op) == XOP_W'(SIGNAL_OP)));
  // R7: status condition bits hold one code bit, bit 15 cleared, rest kept
  a_r7_status_code: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !illegal && !trap) |->
      (!fs_out[FS_CC_HI] && $onehot(fs_out[FS_CC_HI-1:FS_CC_LO])
       && fs_out[REG_W-1:FS_CC_HI+1] == $past(fs_in[REG_W-1:FS_CC_HI+1])
       && fs_out[FS_CC_LO-1:0] == $past(fs_in[FS_CC_LO-1:0])));
  // R8: selected condition field mirrors the status code
  a_r8_field_mirror: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !illegal && !trap) |->
      (cr_out[REG_W-1-CC_W*int'($past(tgt_field[TGT_W-1:2])) -: CC_W]
       == fs_out[FS_CC_HI-1:FS_CC_LO]));
endmodule

// File: tb/test_fp_cmp_cond.sv
module test_fp_cmp_cond;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [63:0] opnd_a = '0, opnd_b = '0;
  logic [4:0]  tgt_field = '0;
  logic [9:0]  ext_op = '0;
  logic [31:0] cr_in = '0, fs_in = '0;
  logic [31:0] cr_out, fs_out;
  logic        done, illegal, trap;

  int n_cmp = 0, n_bad = 0;
  bit finished = 0;

  localparam logic [63:0] PZERO = 64'h0000_0000_0000_0000;
  localparam logic [63:0] NZERO = 64'h8000_0000_0000_0000;
  localparam logic [63:0] PINF  = 64'h7FF0_0000_0000_0000;
  localparam logic [63:0] NINF  = 64'hFFF0_0000_0000_0000;
  localparam logic [63:0] QNAN  = 64'h7FF8_0000_0000_0001;
  localparam logic [63:0] SNAN  = 64'hFFF0_0000_0000_0003;

  always #10 clk = ~clk;

  fp_cmp_cond i_fp_cmp_cond (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .opnd_a(opnd_a), .opnd_b(opnd_b),
    .tgt_field(tgt_field), .ext_op(ext_op), .cr_in(cr_in), .fs_in(fs_in),
    .cr_out(cr_out), .fs_out(fs_out), .done(done), .illegal(illegal), .trap(trap)
  );

  function automatic bit is_nan_b(logic [63:0] v);
    return (v[62:52] == 11'h7FF) && (v[51:0] != 0);
  endfunction

  function automatic logic [3:0] ref_code(logic [63:0] a, logic [63:0] b);
    real ra, rb;
    if (is_nan_b(a) || is_nan_b(b)) return 4'b0001;
    ra = $bitstoreal(a);
    rb = $bitstoreal(b);
    if (ra == rb) return 4'b0010;
    if (ra < rb)  return 4'b1000;
    return 4'b0100;
  endfunction

  task automatic chk(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run_op(logic [63:0] a, logic [63:0] b, logic [4:0] t, logic [9:0] x,
                        logic [31:0] cr, logic [31:0] fs, string req);
    logic [3:0]  c;
    bit          e_ill, e_trap;
    logic [31:0] e_cr, e_fs;
    @(negedge clk);
    opnd_a = a; opnd_b = b; tgt_field = t; ext_op = x; cr_in = cr; fs_in = fs;
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    c = ref_code(a, b);
    e_ill  = ((x != 10'd0) && (x != 10'd32)) || (t[1:0] != 2'b00);
    e_trap = !e_ill && (x == 10'd32) && (is_nan_b(a) || is_nan_b(b));
    e_cr = cr; e_fs = fs;
    if (!e_ill && !e_trap) begin
      e_cr[28 - 4*int'(t[4:2]) +: 4] = c;
      e_fs[15:11] = {1'b0, c};
    end
    chk(done == 1'b1, {req, " R9 done"}, 64'(done), 64'd1);
    chk(illegal == e_ill && trap == e_trap, {req, " R4/R5/R6 flags"},
        64'({illegal, trap}), 64'({e_ill, e_trap}));
    chk(cr_out == e_cr, {req, " R8 cr"}, 64'(cr_out), 64'(e_cr));
    chk(fs_out == e_fs, {req, " R7 status"}, 64'(fs_out), 64'(e_fs));
  endtask

  function automatic logic [63:0] pick_opnd(logic [63:0] other);
    int unsigned k = $urandom_range(0, 9);
    case (k)
      0: return {$urandom, $urandom};
      1: return other;
      2: return ($urandom_range(0, 1) != 0) ? PZERO : NZERO;
      3: return ($urandom_range(0, 1) != 0) ? PINF : NINF;
      4: return ($urandom_range(0, 1) != 0) ? QNAN : SNAN;
      5: return {other[63], ~other[62:0]};
      default: return $realtobits(real'($signed($urandom_range(0, 40)) - 20));
    endcase
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [63:0] a, b;
    logic [4:0]  t;
    logic [9:0]  x;
    logic [31:0] hold_cr;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    // R10: reset state
    chk(cr_out == 0 && fs_out == 0 && !done && !illegal && !trap, "R10 reset",
        {cr_out, fs_out}, 64'd0);
    rst_n = 1'b1;

    // directed corner cases
    run_op(PZERO, NZERO, 5'd0, 10'd0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R3 zeros");
    run_op(QNAN, 64'h3FF0_0000_0000_0000, 5'd28, 10'd0, 32'h1234_5678, 32'h0, "R1 quiet nan");
    run_op(64'h3FF0_0000_0000_0000, SNAN, 5'd8, 10'd32, 32'hA5A5_A5A5, 32'h5A5A, "R6 trap");
    run_op(NINF, PINF, 5'd4, 10'd0, 32'h0, 32'h0, "R2 inf order");
    run_op($realtobits(-2.0), $realtobits(-1.0), 5'd12, 10'd32, 32'h0, 32'hFFFF, "R2 neg");
    run_op($realtobits(3.5), $realtobits(3.5), 5'd16, 10'd0, 32'h0, 32'h0, "R2 equal");
    run_op($realtobits(2.0), $realtobits(-7.0), 5'd20, 10'd0, 32'h0, 32'h0, "R2 gt");
    run_op(PZERO, PZERO, 5'd0, 10'd1, 32'hCAFE_F00D, 32'h1357_9BDF, "R4 bad selector");
    run_op(QNAN, QNAN, 5'd1, 10'd32, 32'hCAFE_F00D, 32'h1357_9BDF, "R5 bad target");
    // R9: outputs hold and done low with no request
    hold_cr = cr_out;
    @(negedge clk);
    chk(!done && cr_out == hold_cr, "R9 hold", {31'd0, done, cr_out}, {32'd0, hold_cr});

    for (int i = 0; i < 400; i++) begin
      a = pick_opnd($realtobits(1.0));
      b = pick_opnd(a);
      t = ($urandom_range(0, 7) != 0) ? {3'($urandom_range(0, 7)), 2'b00} : 5'($urandom);
      x = ($urandom_range(0, 7) != 0) ? (($urandom_range(0, 1) != 0) ? 10'd32 : 10'd0)
                                      : 10'($urandom);
      run_op(a, b, t, x, $urandom, $urandom, "R1/R2 random");
    end

    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule